// File: doc/BRIEF.md
# Interval Timer Interrupt Controller

This block is a small slice of a system controller. It sits on a 32-bit register bus and holds three things: a down-counting interval timer that raises an interrupt when it runs out, an external interrupt mask register, and a set of status registers. Software acknowledges an interrupt by accessing the matching status register. One interrupt line goes out for the timer and one for the inter-processor interrupt (IPI).

A free-running prescaler makes one timer tick every 2^PRESC_W clock cycles. The live count drops by one on each tick, but only while the mask register is nonzero and both the reload value and the live count are positive. When the count reaches zero, the timer line goes high and stays high. An access to the timer status register drops the line and reloads the counter, which starts the next period. The IPI line is set by a one-cycle request input and cleared by an access to its status register.

A read returns its data on `rdata_o` in the cycle after the access. `rdata_o` keeps that value until the next read.

Top module: `tick_intc`

## Requirements
- R1: The window is 4 KB (`addr_i[11:0]`). Bits [11:2] select a 32-bit word and bits [1:0] are ignored. The byte offsets are: 0x000 config, 0x008 CPU ID, 0x010 mask, 0x014 timer value, 0x020 local-bus status, 0x024 timer status and 0x028 IPI status. A read puts its data on `rdata_o` one cycle after the access, and `rdata_o` holds that value through writes and idle cycles.
- R2: A write to the timer value register loads both the reload register and the live count. A read of it returns the reload value, including negative values, and never the live count.
- R3: The live count drops by one per tick only while all three of these hold: the mask is nonzero, the reload value is positive (signed), and the live count is positive (signed). A zero or negative reload never counts and never raises the timer line.
- R4: The timer line rises on the tick that brings the count to zero. The count then stops at zero, and the line stays high until it is acknowledged.
- R5: Any read or write of the timer status register clears the timer line and reloads the live count from the reload register. A read of it returns 0.
- R6: A one-cycle pulse on `ipi_set_i` raises the IPI line on the next cycle. Any access to the IPI status register clears the line, and a read of it returns 0. If a request and an access arrive in the same cycle, the request wins.
- R7: The mask register is fully read/write, and a read returns the last value written.
- R8: A read of the local-bus status register returns 0x24 ((level 8 + 1) << 2) when `lb_pend_i` is high, and 0 otherwise.
- R9: One timer tick occurs every 2^PRESC_W clock cycles. A count of N loaded at edge e raises the timer line at some edge after e+(N-1)·2^PRESC_W and no later than e+N·2^PRESC_W.
- R10: The CPU ID register reads as the CPU_ID parameter and ignores writes. The config register reads as 0. Offsets not listed in R1 read as 0 and ignore writes.
- R11: Reset (`rst_ni` low) clears the mask, the reload register, the live count and `rdata_o`, and drops both interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| lb_pend_i | input | 1 | Local-bus level-8 source pending |
| ipi_set_i | input | 1 | Inter-processor interrupt request pulse |
| rdata_o | output | 32 | Read data, registered |
| timer_irq_o | output | 1 | Interval timer interrupt |
| ipi_irq_o | output | 1 | Inter-processor interrupt |

## Verification
Read data, register updates and the clearing of either interrupt line all take effect at the clock edge that samples the access. The bench drives each access half a cycle before that edge and samples the results at the falling edge that follows. The IPI line follows the same timing, one edge after its request pulse.

The bench cannot know the prescaler phase at the moment it loads the timer. It therefore checks the timer line at two edge counts counted from the loading edge: at (N-1)·2^PRESC_W edges the line must still be low, and at N·2^PRESC_W edges it must be high. This bounds the timer line for every prescaler phase. Gating is checked the same way: the count is loaded with the mask at 0, and after the mask is set the full number of ticks must still elapse before the line rises.

// File: rtl/tick_intc_pkg.sv
package tick_intc_pkg;

  parameter int unsigned ADDR_W = 12;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_CPUID,
    SEL_MASK,
    SEL_TVAL,
    SEL_LBSTAT,
    SEL_TSTAT,
    SEL_ISTAT
  } reg_sel_e;

  // word indices (byte offset / 4)
  localparam logic [WIDX_W-1:0] WI_CFG    = WIDX_W'(10'h000);
  localparam logic [WIDX_W-1:0] WI_CPUID  = WIDX_W'(10'h002);
  localparam logic [WIDX_W-1:0] WI_MASK   = WIDX_W'(10'h004);
  localparam logic [WIDX_W-1:0] WI_TVAL   = WIDX_W'(10'h005);
  localparam logic [WIDX_W-1:0] WI_LBSTAT = WIDX_W'(10'h008);
  localparam logic [WIDX_W-1:0] WI_TSTAT  = WIDX_W'(10'h009);
  localparam logic [WIDX_W-1:0] WI_ISTAT  = WIDX_W'(10'h00A);

  localparam int unsigned LB_LEVEL = 8;
  localparam logic [DATA_W-1:0] LB_CODE = DATA_W'((LB_LEVEL + 1) << 2);

  function automatic reg_sel_e decode_sel(input logic [WIDX_W-1:0] widx);
    reg_sel_e s;
    unique case (widx)
      WI_CFG:    s = SEL_CFG;
      WI_CPUID:  s = SEL_CPUID;
      WI_MASK:   s = SEL_MASK;
      WI_TVAL:   s = SEL_TVAL;
      WI_LBSTAT: s = SEL_LBSTAT;
      WI_TSTAT:  s = SEL_TSTAT;
      WI_ISTAT:  s = SEL_ISTAT;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRESC_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = &cnt_q;

  generate
    if (PRESC_W > 1) begin : g_tick_chk
      assert_tick_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         gate_en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         ack_i,
  output logic [W-1:0] reload_o,
  output logic         irq_o
);

  logic [W-1:0] reload_q, count_q;
  logic         irq_q;
  logic         reload_pos, count_pos, dec_ok;

  assign reload_pos = !reload_q[W-1] && (|reload_q);
  assign count_pos  = !count_q[W-1]  && (|count_q);
  assign dec_ok     = tick_i && gate_en_i && reload_pos && count_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      count_q  <= '0;
    end else if (load_i) begin
      reload_q <= load_val_i;
      count_q  <= load_val_i;
    end else if (ack_i) begin
      count_q  <= reload_q;
    end else if (dec_ok) begin
      count_q  <= count_q - 1'b1;
    end
  end

  // positive count reaching zero: only from exactly one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                irq_q <= 1'b0;
    else if (ack_i)                             irq_q <= 1'b0;
    else if (dec_ok && count_q == W'(1))        irq_q <= 1'b1;
  end

  assign reload_o = reload_q;
  assign irq_o    = irq_q;

  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !ack_i) |=> $stable(count_q));
  assert_hold_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_en_i && !load_i && !ack_i) |=> $stable(count_q));
  assert_irq_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i));
  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);
  assert_load_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> reload_o == $past(load_val_i));

endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import tick_intc_pkg::*;
#(
  parameter logic [DATA_W-1:0] CPU_ID = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lb_pend_i,
  input  logic              ipi_set_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              tval_load_o,
  output logic              tstat_ack_o,
  output logic              ipi_irq_o,
  output logic [DATA_W-1:0] rdata_o
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] mask_q, rdata_q, rd_mux;
  logic              ipi_q, ipi_ack;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^addr_i[1:0];
  assign sel = decode_sel(addr_i[ADDR_W-1:2]);

  assign tval_load_o = req_i && we_i && (sel == SEL_TVAL);
  assign tstat_ack_o = req_i && (sel == SEL_TSTAT);
  assign ipi_ack     = req_i && (sel == SEL_ISTAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             mask_q <= '0;
    else if (req_i && we_i && sel == SEL_MASK) mask_q <= wdata_i;
  end

  // new request wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ipi_q <= 1'b0;
    else if (ipi_set_i) ipi_q <= 1'b1;
    else if (ipi_ack)   ipi_q <= 1'b0;
  end

  always_comb begin
    unique case (sel)
      SEL_CPUID:  rd_mux = CPU_ID;
      SEL_MASK:   rd_mux = mask_q;
      SEL_TVAL:   rd_mux = reload_i;
      SEL_LBSTAT: rd_mux = lb_pend_i ? LB_CODE : '0;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_mux;
  end

  assign mask_o    = mask_q;
  assign ipi_irq_o = ipi_q;
  assign rdata_o   = rdata_q;

  assert_rdata_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  assert_ipi_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_set_i |=> ipi_irq_o);
  assert_ipi_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipi_ack && !ipi_set_i) |=> !ipi_irq_o);
  assert_mask_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(mask_o));

endmodule

// File: rtl/tick_intc.sv
module tick_intc
  import tick_intc_pkg::*;
#(
  parameter int unsigned       PRESC_W = 14,
  parameter logic [DATA_W-1:0] CPU_ID  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lb_pend_i,
  input  logic              ipi_set_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              timer_irq_o,
  output logic              ipi_irq_o
);

  logic              tick;
  logic              tval_load, tstat_ack;
  logic [DATA_W-1:0] mask, reload;

  tick_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  intc_regfile #(.CPU_ID(CPU_ID)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .lb_pend_i   (lb_pend_i),
    .ipi_set_i   (ipi_set_i),
    .reload_i    (reload),
    .mask_o      (mask),
    .tval_load_o (tval_load),
    .tstat_ack_o (tstat_ack),
    .ipi_irq_o   (ipi_irq_o),
    .rdata_o     (rdata_o)
  );

  interval_counter #(.W(DATA_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .gate_en_i  (|mask),
    .load_i     (tval_load),
    .load_val_i (wdata_i),
    .ack_i      (tstat_ack),
    .reload_o   (reload),
    .irq_o      (timer_irq_o)
  );

  assert_tstat_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:2] == WI_TSTAT) |=> rdata_o == '0);

endmodule

// File: tb/tb_tick_intc.sv
module tb_tick_intc;

  localparam int unsigned PW  = 4;
  localparam int unsigned P   = 1 << PW;
  localparam logic [31:0] CID = 32'h0000_0003;
  localparam int unsigned NV  = 21;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, lb_pend = 1'b0, ipi_set = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        timer_irq, ipi_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_intc #(.PRESC_W(PW), .CPU_ID(CID)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .lb_pend_i(lb_pend), .ipi_set_i(ipi_set),
    .rdata_o(rdata), .timer_irq_o(timer_irq), .ipi_irq_o(ipi_irq)
  );

  // {lb_pend, we, addr, wdata, expected read}
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 1'b1, 12'h010, 32'hA5A5_0F0F, 32'h0},         // R7
    {1'b0, 1'b0, 12'h010, 32'h0, 32'hA5A5_0F0F},         // R7
    {1'b0, 1'b0, 12'h013, 32'h0, 32'hA5A5_0F0F},         // R1 low bits ignored
    {1'b0, 1'b1, 12'h010, 32'h0000_0001, 32'h0},         // R7
    {1'b0, 1'b0, 12'h010, 32'h0, 32'h0000_0001},         // R7
    {1'b0, 1'b0, 12'h008, 32'h0, CID},                   // R10
    {1'b0, 1'b1, 12'h008, 32'hFFFF_FFFF, 32'h0},         // R10
    {1'b0, 1'b0, 12'h008, 32'h0, CID},                   // R10
    {1'b0, 1'b1, 12'h000, 32'h1234_5678, 32'h0},         // R10
    {1'b0, 1'b0, 12'h000, 32'h0, 32'h0},                 // R10
    {1'b0, 1'b1, 12'h100, 32'hDEAD_BEEF, 32'h0},         // R10
    {1'b0, 1'b0, 12'h100, 32'h0, 32'h0},                 // R10
    {1'b0, 1'b0, 12'h7FC, 32'h0, 32'h0},                 // R10
    {1'b0, 1'b1, 12'h014, 32'h0000_0009, 32'h0},         // R2
    {1'b0, 1'b0, 12'h014, 32'h0, 32'h0000_0009},         // R2
    {1'b1, 1'b0, 12'h020, 32'h0, 32'h0000_0024},         // R8
    {1'b0, 1'b0, 12'h020, 32'h0, 32'h0},                 // R8
    {1'b0, 1'b1, 12'h014, 32'h0, 32'h0},                 // R2
    {1'b0, 1'b0, 12'h014, 32'h0, 32'h0},                 // R2
    {1'b0, 1'b0, 12'h024, 32'h0, 32'h0},                 // R5
    {1'b0, 1'b0, 12'h028, 32'h0, 32'h0}                  // R6
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // caller is at a falling edge; returns at the falling edge after the sampling edge
  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rdata", rdata, 32'h0);
    chk("R11 timer_irq", {31'b0, timer_irq}, 32'h0);
    chk("R11 ipi_irq", {31'b0, ipi_irq}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    access(1'b0, 12'h010, 32'h0); chk("R11 mask after reset", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      lb_pend = VEC[i][77];
      access(VEC[i][76], VEC[i][75:64], VEC[i][63:32]);
      if (!VEC[i][76]) chk($sformatf("vector %0d R1/R2/R7/R8/R10", i), rdata, VEC[i][31:0]);
    end
    lb_pend = 1'b0;

    // R9/R4: mask=1, load 3
    access(1'b1, 12'h014, 32'd3);
    wait_edges(2*P); chk("R9 early", {31'b0, timer_irq}, 32'h0);
    wait_edges(P);   chk("R9 due R4", {31'b0, timer_irq}, 32'h1);
    access(1'b0, 12'h014, 32'h0); chk("R2 reload readback", rdata, 32'd3);
    wait_edges(4*P); chk("R4 sticky", {31'b0, timer_irq}, 32'h1);

    // R5: read ack clears and reloads
    access(1'b0, 12'h024, 32'h0);
    chk("R5 read zero", rdata, 32'h0);
    chk("R5 cleared", {31'b0, timer_irq}, 32'h0);
    wait_edges(2*P); chk("R5 reload early", {31'b0, timer_irq}, 32'h0);
    wait_edges(P);   chk("R5 reload due", {31'b0, timer_irq}, 32'h1);
    access(1'b1, 12'h024, 32'hFFFF_FFFF);
    chk("R5 write ack", {31'b0, timer_irq}, 32'h0);

    // R3: gated by mask
    access(1'b1, 12'h010, 32'h0);
    access(1'b1, 12'h014, 32'd2);
    wait_edges(4*P); chk("R3 masked no irq", {31'b0, timer_irq}, 32'h0);
    access(1'b1, 12'h010, 32'h8000_0000);
    wait_edges(P);   chk("R3 count held early", {31'b0, timer_irq}, 32'h0);
    wait_edges(P);   chk("R3 count held due", {31'b0, timer_irq}, 32'h1);
    access(1'b0, 12'h024, 32'h0);

    // R3: zero and negative reload
    access(1'b1, 12'h014, 32'h0);
    wait_edges(3*P); chk("R3 zero reload", {31'b0, timer_irq}, 32'h0);
    access(1'b1, 12'h014, 32'h8000_0001);
    wait_edges(3*P); chk("R3 negative reload", {31'b0, timer_irq}, 32'h0);
    access(1'b0, 12'h014, 32'h0); chk("R2 negative readback", rdata, 32'h8000_0001);

    // R6: IPI
    ipi_set = 1'b1; @(posedge clk); @(negedge clk); ipi_set = 1'b0;
    chk("R6 set", {31'b0, ipi_irq}, 32'h1);
    chk("R6 timer unaffected", {31'b0, timer_irq}, 32'h0);
    access(1'b0, 12'h028, 32'h0);
    chk("R6 read zero", rdata, 32'h0);
    chk("R6 cleared", {31'b0, ipi_irq}, 32'h0);
    ipi_set = 1'b1;
    access(1'b1, 12'h028, 32'h0);
    ipi_set = 1'b0;
    chk("R6 set wins", {31'b0, ipi_irq}, 32'h1);
    access(1'b1, 12'h028, 32'h0);
    chk("R6 write ack", {31'b0, ipi_irq}, 32'h0);

    // R11: reset mid-run
    access(1'b1, 12'h010, 32'h5);
    access(1'b1, 12'h014, 32'd1);
    ipi_set = 1'b1; @(posedge clk); @(negedge clk); ipi_set = 1'b0;
    wait_edges(P);
    access(1'b0, 12'h010, 32'h0);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R11 rdata cleared", rdata, 32'h0);
    chk("R11 timer cleared", {31'b0, timer_irq}, 32'h0);
    chk("R11 ipi cleared", {31'b0, ipi_irq}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    access(1'b0, 12'h010, 32'h0); chk("R11 mask", rdata, 32'h0);
    access(1'b0, 12'h014, 32'h0); chk("R11 reload", rdata, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule